// File: doc/BRIEF.md
# Fully Associative Read Cache with Rotating-Pointer Replacement

This block is a small read-only cache in front of a slower block memory. Any memory block may occupy any of its entries. A processor read supplies a byte address. The tag part of that address is compared against every stored tag in the same cycle. If a valid entry matches, the addressed 32-bit word of that entry is returned one cycle later.

On a miss the request stays stalled. The block asks the lower memory for the whole aligned block, writes the returned data, tag and valid bit into a victim entry, and then serves the held request as a hit. A single rotating replacement pointer chooses the victim. The pointer steps forward only when an access lands on the entry it names. This cheaply approximates least-recently-used ordering. Only one refill is in flight at a time.

Top module: `fa_cache`

## Requirements
- R1: The cache holds 64 entries and a block may be placed in any of them. After 64 distinct blocks are loaded from reset, every one of them hits.
- R2: Address bits 31:5 are the tag, bits 4:2 select the word within the block and bits 1:0 are ignored. In the refill data, word w occupies bits 32*w+31 down to 32*w. A response returns word addr[4:2] of the matching block.
- R3: A hit is reported with `req_ready_o` high in the same cycle as the valid request. `rsp_valid_o` is high and `rsp_data_o` holds the word in the following cycle, and only then.
- R4: The replacement pointer moves to the next entry when an access, whether a hit or a refill, touches the entry it names. An access that hits any other entry leaves the pointer unchanged.
- R5: A miss holds `req_ready_o` low. From the next cycle, `fill_req_o` stays high with `fill_addr_o` equal to the request address with bits 4:0 cleared, until `fill_valid_i` is seen. The returned block overwrites the entry under the pointer.
- R6: The pointer wraps from entry 63 to entry 0, so the 65th distinct block after reset evicts the first.
- R7: Reset clears every valid bit and sets the pointer to entry 0. After reset no response or refill request is active, and every first access misses.
- R8: The cycle that accepts `fill_valid_i` writes the data, the tag and the valid bit, and drops `fill_req_o`. The held request is accepted as a hit in the next cycle.
- R9: Only one miss is outstanding. `req_ready_o` stays low for the whole refill.
- R10: `fill_valid_i` is ignored while no refill is pending. It installs nothing, and a later read of that block still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid, held until accepted |
| req_addr_i | input | 32 | Byte address of the read |
| req_ready_o | output | 1 | Request accepted (hit) this cycle |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read word |
| fill_req_o | output | 1 | Block refill request, held until data returns |
| fill_addr_o | output | 32 | Block-aligned refill address |
| fill_valid_i | input | 1 | Refill block is present |
| fill_data_i | input | 256 | Refill block, word w in bits 32*w+31:32*w |

## Verification
`req_ready_o` is combinational, so the bench samples it shortly after the falling edge at which it drove the request. `rsp_valid_o` and `rsp_data_o` are due one clock later, and the bench samples them at the next falling edge. A miss raises `fill_req_o` one edge after the request. The bench checks it, together with a low `req_ready_o`, at every falling edge of a random refill wait. After it pulses `fill_valid_i` for one edge, the bench expects `fill_req_o` low and `req_ready_o` high at the following falling edge. The victim order, including the wrap, is predicted by a bench model of tags, valid bits and pointer. Each hit or miss the bench observes is checked against that model.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } fa_state_e;
endpackage

// File: rtl/fa_tag_cam.sv
module fa_tag_cam #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lookup_tag_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag_i;
      end
    end
    assign match[g] = vld_q[g] && (tag_q[g] == lookup_tag_i);
  end

  // one-hot to binary: at most one entry can match
  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
    end
  end
  assign hit_o = |match;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R1
  AST_FILL_INSTALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)); // R8
endmodule

// File: rtl/fa_data_store.sv
module fa_data_store #(
  parameter int ENTRIES = 64,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 8,
  parameter int BLK_W   = WORD_W * WORDS,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int SEL_W   = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BLK_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [BLK_W-1:0] mem_q [ENTRIES];
  logic [BLK_W-1:0] rd_blk;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_blk    = mem_q[rd_idx_i];
  assign rd_word_o = rd_blk[rd_sel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (touch_i && touch_idx_i == ptr_q) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
  assign ptr_o = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch_i |=> $stable(ptr_q)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == LAST && touch_i && touch_idx_i == LAST) |=> ptr_q == '0); // R6
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 5,
  parameter int TAG_W  = ADDR_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              hit_i,
  input  logic              fill_valid_i,
  output logic              req_ready_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic              fill_accept_o
);
  fa_state_e state_q, state_d;
  logic [TAG_W-1:0] miss_tag_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOKUP: if (req_valid_i && !hit_i) state_d = ST_REFILL;
      ST_REFILL: if (fill_valid_i) state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LOOKUP;
      miss_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOOKUP && req_valid_i && !hit_i) miss_tag_q <= req_tag_i;
    end
  end

  assign req_ready_o   = (state_q == ST_LOOKUP) && req_valid_i && hit_i;
  assign fill_req_o    = (state_q == ST_REFILL);
  assign fill_accept_o = (state_q == ST_REFILL) && fill_valid_i;
  assign fill_addr_o   = {miss_tag_q, {OFFS_W{1'b0}}};

  AST_MISS_STARTS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_i && !fill_req_o) |=> fill_req_o); // R5
  AST_FILL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> fill_req_o && $stable(fill_addr_o)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> !req_ready_o); // R9
  AST_FILL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_valid_i) |=> !fill_req_o); // R8
endmodule

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ENTRIES     = 64,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int WORD_W      = 32,
  localparam int BLK_W      = BLOCK_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [BLK_W-1:0]  fill_data_i
);
  localparam int OFFS_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int WORDS  = BLK_W / WORD_W;
  localparam int SEL_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [TAG_W-1:0]  req_tag;
  logic [SEL_W-1:0]  req_sel;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  ptr;
  logic              fill_accept;
  logic              touch;
  logic [IDX_W-1:0]  touch_idx;
  logic [WORD_W-1:0] rd_word;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  assign req_tag = req_addr_i[ADDR_W-1:OFFS_W];
  assign req_sel = req_addr_i[OFFS_W-1:BYTE_W];

  fa_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .TAG_W(TAG_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i,
    .req_tag_i     (req_tag),
    .hit_i         (hit),
    .fill_valid_i,
    .req_ready_o,
    .fill_req_o,
    .fill_addr_o,
    .fill_accept_o (fill_accept)
  );

  // the tag written on refill is the latched miss tag
  fa_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .clk_i, .rst_ni,
    .lookup_tag_i (req_tag),
    .wr_en_i      (fill_accept),
    .wr_idx_i     (ptr),
    .wr_tag_i     (fill_addr_o[ADDR_W-1:OFFS_W]),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx)
  );

  fa_data_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .WORDS(WORDS), .BLK_W(BLK_W),
                  .IDX_W(IDX_W), .SEL_W(SEL_W)) u_data (
    .clk_i,
    .wr_en_i   (fill_accept),
    .wr_idx_i  (ptr),
    .wr_data_i (fill_data_i),
    .rd_idx_i  (hit_idx),
    .rd_sel_i  (req_sel),
    .rd_word_o (rd_word)
  );

  // refill and hit are exclusive: refill state blocks acceptance
  assign touch     = req_ready_o | fill_accept;
  assign touch_idx = fill_accept ? ptr : hit_idx;

  fa_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk_i, .rst_ni,
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .ptr_o       (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_ready_o;
      if (req_ready_o) rsp_data_q <= rd_word;
    end
  end
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R3
  AST_RSP_ONLY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R3
endmodule

// File: tb/fa_cache_tb_top.sv
module fa_cache_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic         req_valid_i = 1'b0;
  logic [31:0]  req_addr_i  = '0;
  logic         req_ready_o;
  logic         rsp_valid_o;
  logic [31:0]  rsp_data_o;
  logic         fill_req_o;
  logic [31:0]  fill_addr_o;
  logic         fill_valid_i = 1'b0;
  logic [255:0] fill_data_i  = '0;

  fa_cache dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .rsp_valid_o, .rsp_data_o, .fill_req_o, .fill_addr_o,
    .fill_valid_i, .fill_data_i
  );

  int checks = 0;
  int errors = 0;
  logic [26:0] ref_tag [64];
  bit          ref_vld [64];
  int          ref_ptr = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] blk(input logic [26:0] t);
    logic [255:0] b;
    for (int w = 0; w < 8; w++) b[w*32 +: 32] = {t, 3'(w), 2'b00} ^ 32'hC3A5_5A3C;
    return b;
  endfunction

  function automatic int ref_find(input logic [26:0] t);
    for (int i = 0; i < 64; i++) if (ref_vld[i] && ref_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic do_read(input logic [31:0] addr, input int lat, output bit saw_miss);
    logic [26:0] t;
    logic [31:0] ew;
    logic [255:0] b;
    int idx;
    t   = addr[31:5];
    b   = blk(t);
    ew  = b[addr[4:2]*32 +: 32];
    idx = ref_find(t);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = addr;
    #1;
    saw_miss = !req_ready_o;
    chk(saw_miss == (idx < 0), "R4 R5 R6 hit/miss vs model", 64'(saw_miss), 64'(idx < 0));
    if (saw_miss) begin
      @(negedge clk_i); #1;
      chk(fill_req_o == 1'b1, "R5 fill request raised", 64'(fill_req_o), 64'd1);
      chk(fill_addr_o == {t, 5'b0}, "R5 fill address aligned", 64'(fill_addr_o), 64'({t, 5'b0}));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk_i); #1;
        chk(fill_req_o && !req_ready_o, "R9 stall held during refill", 64'({fill_req_o, req_ready_o}), 64'b10);
      end
      fill_valid_i = 1'b1;
      fill_data_i  = b;
      @(negedge clk_i);
      fill_valid_i = 1'b0;
      fill_data_i  = '0;
      if (idx < 0) begin
        ref_tag[ref_ptr] = t;
        ref_vld[ref_ptr] = 1'b1;
        ref_ptr = (ref_ptr + 1) % 64;
      end
      idx = ref_find(t);
      #1;
      chk(!fill_req_o, "R8 refill request dropped", 64'(fill_req_o), 64'd0);
      chk(req_ready_o == 1'b1, "R8 held request hits after refill", 64'(req_ready_o), 64'd1);
    end
    if (idx == ref_ptr) ref_ptr = (ref_ptr + 1) % 64;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
    chk(rsp_valid_o == 1'b1, "R3 response valid one cycle after accept", 64'(rsp_valid_o), 64'd1);
    chk(rsp_data_o == ew, "R2 word select", 64'(rsp_data_o), 64'(ew));
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit m;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) ref_vld[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!rsp_valid_o && !fill_req_o, "R7 idle outputs in reset", 64'({rsp_valid_o, fill_req_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!rsp_valid_o && !fill_req_o, "R7 idle outputs after reset", 64'({rsp_valid_o, fill_req_o}), 64'd0);

    // fill all 64 entries with distinct blocks: each first access misses
    for (int i = 0; i < 64; i++) begin
      do_read({27'h100 + 27'(i), 3'(i), 2'(i)}, i % 3, m);
      chk(m == 1'b1, "R7 compulsory miss after reset", 64'(m), 64'd1);
    end
    for (int i = 0; i < 64; i++) begin
      do_read({27'h100 + 27'(i), 3'(7 - (i % 8)), 2'b11}, 0, m);
      chk(m == 1'b0, "R1 all 64 blocks resident", 64'(m), 64'd0);
    end
    // pointer is at 0; a hit on entry 5 must not move it
    do_read({27'h105, 5'h00}, 0, m);
    do_read({27'h300, 5'h04}, 1, m);  // evicts entry 0 (wrap)
    chk(m == 1'b1, "R6 new block misses", 64'(m), 64'd1);
    do_read({27'h100, 5'h00}, 0, m);
    chk(m == 1'b1, "R6 first block evicted after wrap", 64'(m), 64'd1);
    // that refill went to entry 1; pointer now 2. hit entry 2 -> pointer 3
    do_read({27'h102, 5'h08}, 0, m);
    chk(m == 1'b0, "R4 entry under pointer hits", 64'(m), 64'd0);
    do_read({27'h301, 5'h1C}, 2, m);  // victim entry 3
    do_read({27'h102, 5'h10}, 0, m);
    chk(m == 1'b0, "R4 touched entry kept", 64'(m), 64'd0);
    do_read({27'h103, 5'h10}, 0, m);
    chk(m == 1'b1, "R4 pointer advanced past touched entry", 64'(m), 64'd1);

    // spurious fill with nothing pending
    @(negedge clk_i);
    fill_valid_i = 1'b1;
    fill_data_i  = blk(27'h4444);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    #1;
    chk(!fill_req_o && !rsp_valid_o, "R10 stray fill produces nothing", 64'({fill_req_o, rsp_valid_o}), 64'd0);
    do_read({27'h4444, 5'h00}, 0, m);
    chk(m == 1'b1, "R10 stray fill installed nothing", 64'(m), 64'd1);

    // random mix over a pool larger than the cache
    for (int n = 0; n < 1200; n++) begin
      logic [31:0] a;
      a = {27'h50000 + 27'($urandom % 90), 5'($urandom)};
      do_read(a, int'($urandom % 4), m);
      if ($urandom % 5 == 0) @(negedge clk_i);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule